// File: doc/BRIEF.md
# Master-Mode Serial Result Transmitter

This block is the output stage of a data converter that supplies its own serial clock. Each time the converter signals that a result is ready, the block keeps a copy of the word and marks it as waiting. When the host enables the port, the block sends the word most significant bit first on a serial data line. The serial clock is made by dividing the system clock, and a frame-sync line marks the valid bits. The polarity of the frame-sync line can be selected.

A read-mode input decides when a frame may begin. In one setting, the waiting word is sent while the next conversion is running (busy high). In the other, the block waits until the converter is idle (busy low). The chip-select and read-enable inputs are both active low, and both must stay low for the whole frame. If either one rises during a frame, the frame is dropped and the same word is sent again, from its first bit, the next time the port is enabled.

Top module: `sertx_master`

## Requirements
- R1: A frame begins only when a word is waiting, `cs_n` and `rd_n` are both low, and the read-mode condition of R2 holds. The outputs enter the frame at the clock edge that samples these conditions.
- R2: With `read_during` = 1, a frame may begin only while `busy_in` = 1. With `read_during` = 0, a frame may begin only while `busy_in` = 0.
- R3: `sclk_o` is low whenever no frame is active. During a frame it runs exactly DATA_W periods of CLK_DIV system cycles each. Each period is low for its first CLK_DIV/2 cycles and high for the rest.
- R4: `sdout_o` carries the word most significant bit first. Each bit is presented at the start of its period, while `sclk_o` is low, and is held for the whole period. `sdout_o` is 0 outside a frame.
- R5: The frame-sync line is at its active level for exactly DATA_W*CLK_DIV system cycles in a frame that completes.
- R6: With `sync_inv` = 0 the frame-sync line is active high. With `sync_inv` = 1 it is active low. Outside a frame it sits at the inactive level.
- R7: A pulse on `conv_done` captures `result_in` and marks it as waiting. Each captured word is sent once. A capture during a frame does not alter that frame, and the new word follows it.
- R8: If `cs_n` or `rd_n` is high during a frame, all outputs return to idle at the next edge. The word stays waiting and is resent in full, starting at its first bit.
- R9: While reset is asserted, `sclk_o` and `sdout_o` are 0, the sync line is inactive, and no word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is ready |
| result_in | input | DATA_W | Conversion result captured on `conv_done` |
| busy_in | input | 1 | Converter is in a conversion |
| read_during | input | 1 | 1: send during conversion; 0: send after conversion |
| sync_inv | input | 1 | 0: frame sync active high; 1: active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk_o | output | 1 | Generated serial clock |
| sdout_o | output | 1 | Serial data, most significant bit first |
| sync_o | output | 1 | Frame sync |

## Verification
The bench builds the block with DATA_W = 16 and CLK_DIV = 4. A full frame therefore lasts 64 cycles, which leaves room for many frames in one run: the edge words, both read modes, both sync polarities, a dropped frame and a capture during a frame. With the divider this small, the low and high halves of each serial clock period are two cycles each. The bench can therefore hit the bit boundary and the last period exactly, and a one-cycle error in a count shows up as a visible mismatch.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic {
        RM_AFTER  = 1'b0,
        RM_DURING = 1'b1
    } rmode_e;

    function automatic logic mode_allows(rmode_e mode, logic busy);
        return (mode == RM_DURING) ? busy : !busy;
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int CLK_DIV = 4,
    parameter int NBITS   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic sclk_phase,
    output logic period_end,
    output logic last_period
);
    localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int HALF = CLK_DIV / 2;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [BW-1:0] bitn;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.div  = '0;
            st_d.bitn = '0;
        end else if (run) begin
            if (st_q.div == DW'(CLK_DIV - 1)) begin
                st_d.div  = '0;
                st_d.bitn = st_q.bitn + 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_phase  = (st_q.div >= DW'(HALF));
    assign period_end  = (st_q.div == DW'(CLK_DIV - 1));
    assign last_period = (st_q.bitn == BW'(NBITS - 1));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = load_val;
        else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/sertx_capture.sv
module sertx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_done,
    input  logic [W-1:0] result_in,
    input  logic         take,
    input  logic         retry,
    output logic [W-1:0] held,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         pend;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (conv_done) begin
            cap_d.word = result_in;
            cap_d.pend = 1'b1;
        end else if (take) begin
            cap_d.pend = 1'b0;
        end else if (retry) begin
            cap_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign held    = cap_q.word;
    assign pending = cap_q.pend;

endmodule

// File: rtl/sertx_master.sv
module sertx_master
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result_in,
    input  logic              busy_in,
    input  logic              read_during,
    input  logic              sync_inv,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              sclk_o,
    output logic              sdout_o,
    output logic              sync_o
);
    typedef struct packed {
        logic active;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              gate_ok;
    logic              start;
    logic              abort;
    logic              finish;
    logic              run;
    logic              pending;
    logic [DATA_W-1:0] held;
    logic              sclk_phase;
    logic              period_end;
    logic              last_period;
    logic              msb;

    assign gate_ok = !cs_n && !rd_n;
    assign start   = !ctl_q.active && pending && gate_ok
                   && mode_allows(rmode_e'(read_during), busy_in);
    assign abort   = ctl_q.active && !gate_ok;
    assign run     = ctl_q.active && gate_ok;
    assign finish  = run && period_end && last_period;

    always_comb begin
        ctl_d = ctl_q;
        if (start)                ctl_d.active = 1'b1;
        else if (abort || finish) ctl_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sertx_capture #(.W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .result_in (result_in),
        .take      (start),
        .retry     (abort),
        .held      (held),
        .pending   (pending)
    );

    sertx_bit_timer #(.CLK_DIV(CLK_DIV), .NBITS(DATA_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (start),
        .run         (run),
        .sclk_phase  (sclk_phase),
        .period_end  (period_end),
        .last_period (last_period)
    );

    sertx_shifter #(.W(DATA_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (held),
        .shift    (run && period_end),
        .msb      (msb)
    );

    assign sclk_o  = ctl_q.active && sclk_phase;
    assign sdout_o = ctl_q.active && msb;
    assign sync_o  = ctl_q.active ^ sync_inv;

endmodule

// File: rtl/sertx_master_chk.sv
module sertx_master_chk #(
    parameter int DATA_W  = 16,
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy_in,
    input logic read_during,
    input logic sync_inv,
    input logic cs_n,
    input logic rd_n,
    input logic sclk_o,
    input logic sdout_o,
    input logic sync_o
);
    localparam int FRAME = DATA_W * CLK_DIV;
    localparam int LW    = $clog2(FRAME) + 2;

    logic          act;
    logic [LW-1:0] len_q;

    assign act = sync_o ^ sync_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   len_q <= '0;
        else if (act) len_q <= len_q + 1'b1;
        else          len_q <= '0;
    end

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !sclk_o);

    // R4
    data_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdout_o));

    // R4
    data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !sdout_o);

    // R1
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $past(!cs_n && !rd_n));

    // R2
    start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $past(read_during ? busy_in : !busy_in));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(act) && $past(!cs_n && !rd_n)) |-> (len_q == LW'(FRAME)));

    // R5
    frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LW'(FRAME));

    // R8
    drop_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (cs_n || rd_n)) |=> !act);

endmodule

bind sertx_master sertx_master_chk #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_in     (busy_in),
    .read_during (read_during),
    .sync_inv    (sync_inv),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .sclk_o      (sclk_o),
    .sdout_o     (sdout_o),
    .sync_o      (sync_o)
);

// File: tb/sim_sertx_master.sv
module sim_sertx_master;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int DIV = 4;
    localparam int FRAME = W * DIV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] result_in = '0;
    logic         busy_in = 1'b0;
    logic         read_during = 1'b0;
    logic         sync_inv = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         sclk_o, sdout_o, sync_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_master #(.DATA_W(W), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .result_in(result_in),
        .busy_in(busy_in), .read_during(read_during), .sync_inv(sync_inv),
        .cs_n(cs_n), .rd_n(rd_n), .sclk_o(sclk_o), .sdout_o(sdout_o), .sync_o(sync_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int           pos = -1;
    bit           pend = 0;
    logic [W-1:0] held = '0;
    logic [W-1:0] word = '0;
    logic [W-1:0] sent_q[$];
    int           starts = 0;
    int           frames_done = 0;
    int           frames_dropped = 0;
    bit           prev_act = 0;
    logic [W-1:0] rx_word = '0;
    int           rx_bits = 0;

    always @(posedge sclk_o) begin
        rx_word = {rx_word[W-2:0], sdout_o};
        rx_bits++;
    end

    always @(posedge clk) begin
        bit gate, mode_ok, exp_act;
        logic [W-1:0] done_word;
        if (!rst_n) begin
            pos = -1; pend = 0; held = '0;
        end else begin
            gate    = !cs_n && !rd_n;
            mode_ok = read_during ? busy_in : !busy_in;
            if (pos >= 0) begin
                if (!gate) begin pos = -1; pend = 1; end
                else if (pos == FRAME - 1) pos = -1;
                else pos++;
            end else if (pend && gate && mode_ok) begin
                pos = 0; word = held; pend = 0; starts++;
                sent_q.push_back(held);
            end
            if (conv_done) begin held = result_in; pend = 1; end
        end
        #1;
        exp_act = (pos >= 0);
        check("R3 sclk", sclk_o, exp_act && ((pos % DIV) >= DIV/2));
        check("R4 sdout", sdout_o, exp_act && word[W-1-pos/DIV]);
        check("R5 R6 sync", sync_o, exp_act ^ sync_inv);
        if (prev_act && !exp_act) begin
            done_word = sent_q.pop_front();
            if (rx_bits == W) begin
                check("R4 R7 received word", rx_word, done_word);
                frames_done++;
            end else begin
                frames_dropped++;
            end
        end
        if (!exp_act) rx_bits = 0;
        prev_act = exp_act;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic capture(input logic [W-1:0] v);
        @(negedge clk); conv_done = 1'b1; result_in = v;
        @(negedge clk); conv_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0, f0;
        cycles(4);
        // R9 reset state
        check("R9 sclk", sclk_o, 0);
        check("R9 sdout", sdout_o, 0);
        check("R9 sync", sync_o, 0);
        rst_n = 1'b1;
        cycles(4);
        check("R9 nothing pending", starts, 0);

        // R1 R2 after-mode frames with several words
        cs_n = 1'b0; rd_n = 1'b0;
        capture(16'hA5C3); cycles(FRAME + 6);
        capture(16'hFFFF); cycles(FRAME + 6);
        capture(16'h0001); cycles(FRAME + 6);
        capture(16'h8000); cycles(FRAME + 6);
        check("R7 four frames", frames_done, 4);

        // R2 during-mode: blocked while busy low
        read_during = 1'b1; s0 = starts;
        capture(16'h3C5A); cycles(30);
        check("R2 during-mode waits for busy", starts, s0);
        busy_in = 1'b1; cycles(FRAME + 6);
        check("R2 during-mode sends", starts, s0 + 1);

        // R2 after-mode: blocked while busy high
        read_during = 1'b0; s0 = starts;
        capture(16'h1234); cycles(30);
        check("R2 after-mode waits for idle", starts, s0);
        busy_in = 1'b0; cycles(FRAME + 6);
        check("R2 after-mode sends", starts, s0 + 1);

        // R6 inverted sync
        sync_inv = 1'b1; cycles(2);
        check("R6 idle level inverted", sync_o, 1);
        capture(16'h0F0F); cycles(FRAME + 6);
        sync_inv = 1'b0;

        // R1 chip select gating
        cs_n = 1'b1; s0 = starts;
        capture(16'h6789); cycles(30);
        check("R1 no frame without select", starts, s0);
        cs_n = 1'b0; cycles(FRAME + 6);
        check("R1 frame after select", starts, s0 + 1);

        // R8 drop and resend
        f0 = frames_done;
        capture(16'hBEEF); cycles(20);
        rd_n = 1'b1; cycles(2);
        check("R8 sync idle after release", sync_o, 0);
        check("R8 sclk idle after release", sclk_o, 0);
        cycles(5);
        rd_n = 1'b0; cycles(FRAME + 6);
        check("R8 one dropped frame", frames_dropped, 1);
        check("R8 resent in full", frames_done, f0 + 1);

        // R7 capture during frame
        f0 = frames_done; s0 = starts;
        capture(16'h1111); cycles(10);
        capture(16'h2222); cycles(2 * FRAME + 10);
        check("R7 both words sent", frames_done, f0 + 2);
        check("R7 each sent once", starts, s0 + 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule